// File: doc/BRIEF.md
# Open-LED Status Capture and Fault Flag

This block watches the sixteen output channels of a constant-current LED driver for open loads. Each channel has a comparator that reports when the channel's output voltage sits below the open-load threshold. That reading means something only for a channel that is switched on while the outputs are enabled. After every latch event the block waits until the staggered turn-on of all channels has settled. It then takes one qualified snapshot of the comparators and holds it as a pending status word.

The pending word is exposed on `lod_word` so that the serial shift chain can load it in the cycle of the next latch strobe. The block clears its copy on that same edge. As a result, the status read out at one update always belongs to the previous update.

Independently of the snapshot, an active-low fault output follows the live qualified comparator vector and the over-temperature flag, one register stage late. Holding the output enable inactive removes the open-load term, so a host can tell a thermal fault from an open-load fault.

Top module: `led_open_fault_mon`

## Requirements
- R1: While reset is held, and on the first clock after it, `lod_word` is all zeros and `fault_n` is 1 (released).
- R2: A snapshot is written exactly SAMPLE_DLY = STAGGER_CYC*(CHANNELS-1)+SETTLE_CYC rising edges after the edge that sees `latch_stb` high (34 with default parameters). Before that edge, `lod_word` reads zero.
- R3: Bit i of the snapshot is 1 only when, at the sampling edge, `oe_n` is 0, `chan_on[i]` is 1 and `out_low[i]` is 1. A comparator on a switched-off channel never sets a bit.
- R4: Once taken, the snapshot is held unchanged while the inputs change, up to the next strobe.
- R5: In the cycle where `latch_stb` is high, `lod_word` still shows the held snapshot for hand-off. From the following edge it reads zero and a new window starts. A strobe arriving before the window ends, or on the very edge the window would end, cancels that snapshot.
- R6: `fault_n` goes to 0 on the first edge after a cycle in which `over_temp` is 1, or in which any channel has `oe_n`=0, `chan_on`=1 and `out_low`=1. This includes the edge right after a strobe that turns on an open channel, without waiting for the snapshot window. Otherwise `fault_n` goes to 1.
- R7: With `oe_n`=1, open-load conditions leave `fault_n` at 1 and produce an all-zero snapshot. Only `over_temp` can pull `fault_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| latch_stb | input | 1 | One-cycle pulse marking a latch rising edge; `chan_on` already carries the newly latched value in this cycle |
| oe_n | input | 1 | Output enable, active low |
| chan_on | input | CHANNELS | Latched per-channel on/off vector |
| out_low | input | CHANNELS | Per-channel comparator: output voltage below open-load threshold |
| over_temp | input | 1 | Over-temperature flag |
| lod_word | output | CHANNELS | Pending open-load status word for the shift chain |
| fault_n | output | 1 | Combined fault indication, active low |

## Verification
The two functions that can fall in the same cycle are the hand-off-and-clear on a strobe and the end of the settle window. When both occur, the strobe takes priority and the snapshot is dropped. The bench provokes this by issuing a second strobe exactly SAMPLE_DLY edges after the first. It expects `lod_word` to be zero during that strobe and afterwards, and then expects a fresh snapshot a full window after the second strobe. A shorter interval, and the immediate fault response on the strobe edge while the window is still counting, are judged the same way.

// File: rtl/led_open_pkg.sv
// led_open_pkg
// Shared constants and helpers for the open-load monitor.
// Assumes: channel count and timing counts are small positive integers.
package led_open_pkg;

    // Default channel count and stagger timing, in system clocks.
    localparam int unsigned DEF_CHANNELS    = 16;
    localparam int unsigned DEF_STAGGER_CYC = 2;
    localparam int unsigned DEF_SETTLE_CYC  = 4;

    // Cycles from strobe to snapshot: last channel's stagger plus settle time.
    function automatic int unsigned sample_delay(input int unsigned ch,
                                                 input int unsigned stag,
                                                 input int unsigned settle);
        return stag * (ch - 1) + settle;
    endfunction

endpackage

// File: rtl/lod_settle_timer.sv
// lod_settle_timer
// Counts a fixed settle window after each restart pulse and emits a
// one-cycle fire pulse on the cycle whose closing edge ends the window.
// Assumes: DLY_CYC >= 1. A restart always wins over a pending fire.
module lod_settle_timer #(
    parameter int unsigned DLY_CYC = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic fire_o
);
    localparam int unsigned CW = $clog2(DLY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DLY_CYC);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;
    logic          busy;

    // Load on restart, count down while busy, go idle at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (restart_i) begin
            cnt  <= LOAD;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == ONE) begin
                cnt  <= '0;
                busy <= 1'b0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // Fire on the final count unless a restart arrives in the same cycle.
    always_comb fire_o = busy && (cnt == ONE) && !restart_i;

    assert_fire_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !busy);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
    assert_restart_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (busy && cnt == LOAD));
endmodule

// File: rtl/lod_status_capture.sv
// lod_status_capture
// Holds the pending open-load word. It clears on a hand-off strobe and
// loads the qualified detect vector on a sample pulse.
// Assumes: clear and sample are never both high (the timer guarantees it).
module lod_status_capture #(
    parameter int unsigned CHANNELS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                sample_i,
    input  logic [CHANNELS-1:0] detect_i,
    output logic [CHANNELS-1:0] word_o
);
    // Pending word: zero after hand-off, snapshot after the window.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (clear_i)  word_o <= '0;
        else if (sample_i) word_o <= detect_i;
    end

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && sample_i));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !sample_i) |=> $stable(word_o));
endmodule

// File: rtl/lod_fault_gen.sv
// lod_fault_gen
// Registers the combined fault indication from the live qualified
// open-load vector and the thermal flag. Output is active low.
// Assumes: the live vector is already gated by output enable and on state.
module lod_fault_gen #(
    parameter int unsigned CHANNELS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                over_temp_i,
    input  logic [CHANNELS-1:0] live_open_i,
    output logic                fault_n_o
);
    // Pull low on any open channel or over-temperature, release otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n_o <= 1'b1;
        else        fault_n_o <= !(over_temp_i || (|live_open_i));
    end

    assert_thermal_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp_i |=> !fault_n_o);
    assert_open_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_open_i) |=> !fault_n_o);
endmodule

// File: rtl/led_open_fault_mon.sv
// led_open_fault_mon
// Top of the open-load monitor. It qualifies each channel's comparator
// with the enable and on state, snapshots the result one settle window
// after each latch strobe, and drives the active-low fault output.
// Assumes: latch_stb is a one-cycle pulse, chan_on already carries the
// new latched value in the strobe cycle, and strobes are spaced more than
// SAMPLE_DLY cycles apart when a snapshot is wanted.
module led_open_fault_mon #(
    parameter int unsigned CHANNELS    = led_open_pkg::DEF_CHANNELS,
    parameter int unsigned STAGGER_CYC = led_open_pkg::DEF_STAGGER_CYC,
    parameter int unsigned SETTLE_CYC  = led_open_pkg::DEF_SETTLE_CYC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_stb,
    input  logic                oe_n,
    input  logic [CHANNELS-1:0] chan_on,
    input  logic [CHANNELS-1:0] out_low,
    input  logic                over_temp,
    output logic [CHANNELS-1:0] lod_word,
    output logic                fault_n
);
    localparam int unsigned SAMPLE_DLY =
        led_open_pkg::sample_delay(CHANNELS, STAGGER_CYC, SETTLE_CYC);

    logic [CHANNELS-1:0] live_open;
    logic                sample_fire;

    // Per-channel qualification: enabled, switched on, output below threshold.
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_qual
        always_comb live_open[ch] = !oe_n && chan_on[ch] && out_low[ch];
    end

    lod_settle_timer #(.DLY_CYC(SAMPLE_DLY)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (latch_stb),
        .fire_o    (sample_fire)
    );

    lod_status_capture #(.CHANNELS(CHANNELS)) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (latch_stb),
        .sample_i (sample_fire),
        .detect_i (live_open),
        .word_o   (lod_word)
    );

    lod_fault_gen #(.CHANNELS(CHANNELS)) fault_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .over_temp_i (over_temp),
        .live_open_i (live_open),
        .fault_n_o   (fault_n)
    );

    assert_handoff_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> (lod_word == '0));
    assert_only_on_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_fire |=> ((lod_word & ~$past(chan_on)) == '0));
    assert_oe_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_fire && oe_n) |=> (lod_word == '0));
    assert_oe_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !over_temp) |=> fault_n);
endmodule

// File: tb/led_open_fault_mon_tb_top.sv
module led_open_fault_mon_tb_top;
    localparam int CH  = 16;
    localparam int DLY = 2 * (CH - 1) + 4;  // R2 window with default parameters

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          latch_stb = 1'b0;
    logic          oe_n = 1'b1;
    logic [CH-1:0] chan_on = '0;
    logic [CH-1:0] out_low = '0;
    logic          over_temp = 1'b0;
    logic [CH-1:0] lod_word;
    logic          fault_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    led_open_fault_mon dut_i (
        .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .oe_n(oe_n),
        .chan_on(chan_on), .out_low(out_low), .over_temp(over_temp),
        .lod_word(lod_word), .fault_n(fault_n)
    );

    // Vector: {chan_on, out_low, oe_n, expected word}
    localparam logic [48:0] VEC [6] = '{
        {16'hFFFF, 16'h0000, 1'b0, 16'h0000},
        {16'hFFFF, 16'h0081, 1'b0, 16'h0081},
        {16'h00F0, 16'h0FF0, 1'b0, 16'h00F0},
        {16'hA5A5, 16'hFFFF, 1'b0, 16'hA5A5},
        {16'hFFFF, 16'hFFFF, 1'b1, 16'h0000},
        {16'h8001, 16'h8000, 1'b0, 16'h8000}
    };

    task automatic chk_word(input string req, input logic [CH-1:0] exp);
        n_chk++;
        if (lod_word !== exp) begin
            n_bad++;
            $display("FAIL %s lod_word actual=%h expected=%h", req, lod_word, exp);
        end
    endtask

    task automatic chk_fault(input string req, input logic exp);
        n_chk++;
        if (fault_n !== exp) begin
            n_bad++;
            $display("FAIL %s fault_n actual=%b expected=%b", req, fault_n, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Pulse the strobe for one cycle; returns at the negedge after its edge.
    task automatic strobe();
        latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk_word("R1 in reset", '0);
        chk_fault("R1 in reset", 1'b1);
        rst_n = 1'b1;
        cyc(1);
        chk_word("R1 after reset", '0);
        chk_fault("R1 after reset", 1'b1);

        // Table walk: R2 timing, R3 qualification, R6/R7 fault follow-up
        for (int v = 0; v < 6; v++) begin
            chan_on = VEC[v][48:33];
            out_low = VEC[v][32:17];
            oe_n    = VEC[v][16];
            strobe();
            cyc(DLY - 1);
            chk_word("R2 before window end", '0);
            cyc(1);
            chk_word("R3 snapshot", VEC[v][15:0]);
            chk_fault("R6/R7 live fault", !(VEC[v][15:0] != '0));
            cyc(3);
        end

        // R4: snapshot held as inputs change; R5 hand-off then clear
        chan_on = 16'h00FF; out_low = 16'h0003; oe_n = 1'b0;
        strobe();
        cyc(DLY);
        chk_word("R3 directed", 16'h0003);
        out_low = 16'h00F0; chan_on = 16'hFF00;
        cyc(5);
        chk_word("R4 held", 16'h0003);
        latch_stb = 1'b1;
        #1 chk_word("R5 hand-off visible in strobe cycle", 16'h0003);
        @(negedge clk);
        latch_stb = 1'b0;
        chk_word("R5 cleared after strobe", '0);

        // R5: early strobe cancels snapshot and restarts window
        out_low = 16'hFFFF; chan_on = 16'h0F0F;
        cyc(DLY / 2);
        out_low = 16'h0101;
        strobe();
        cyc(DLY - 1);
        chk_word("R5 early strobe restarts window", '0);
        cyc(1);
        chk_word("R5 snapshot after restart", 16'h0101);

        // R5: strobe on the exact edge the window ends
        chan_on = 16'hFFFF; out_low = 16'h0010;
        strobe();
        cyc(DLY - 1);
        chan_on = 16'hFFFF; out_low = 16'h0200;
        strobe();
        chk_word("R5 coincident strobe drops snapshot", '0);
        cyc(DLY - 1);
        chk_word("R5 coincident zero until new window", '0);
        cyc(1);
        chk_word("R5 coincident new snapshot", 16'h0200);
        cyc(2);

        // R6: fault on the edge right after a strobe enabling an open channel
        chan_on = '0; out_low = 16'h0004; oe_n = 1'b0;
        cyc(2);
        chk_fault("R6 off channel no fault", 1'b1);
        chan_on = 16'h0004;
        strobe();
        chk_fault("R6 immediate on strobe", 1'b0);
        chk_word("R6 word still zero in window", '0);
        cyc(DLY);

        // R7: enable inactive masks open faults; thermal still reaches output
        oe_n = 1'b1;
        cyc(1);
        chk_fault("R7 open masked", 1'b1);
        over_temp = 1'b1;
        cyc(1);
        chk_fault("R7 thermal with enable off", 1'b0);
        over_temp = 1'b0; out_low = '0; oe_n = 1'b0;
        cyc(1);
        chk_fault("R6 released", 1'b1);

        // R1: reset mid-operation clears a held word
        out_low = 16'h0004;
        strobe();
        cyc(DLY);
        chk_word("R3 pre-reset snapshot", 16'h0004);
        rst_n = 1'b0;
        cyc(1);
        chk_word("R1 reset clears word", '0);
        chk_fault("R1 reset releases fault", 1'b1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule